// File: doc/BRIEF.md
# Programmable DRAM Refresh Timer

This block paces CAS-before-RAS refresh for a DRAM controller. A 14-bit rate value sits behind a small 16-bit register port. A free-running up counter, clocked by the bus clock, is compared against that value, and each time the two are equal a refresh falls due. The block then raises a refresh request. The request stays up until the DRAM controller accepts it with an acknowledge, and an acknowledge counts only while the bus is ready.

Timing comes from an equality match, not from a reload. If software lowers the rate below the counter's present value, the counter runs on through its wrap before it can match again. When an external cycle keeps the bus busy for longer than one refresh period, the next refresh due merges into the request already waiting. That refresh is lost, and a sticky flag in a status word records the loss. A rate of zero stops refresh altogether.

Top module: `refresh_timer`

## Requirements
- R1: Address 0 reads the rate register: bits 13:0 hold the rate, and bits 15:14 always read 0, whatever was written to them.
- R2: After reset the rate reads 0x1FFF, the request output is low, and the status word at address 1 reads 0.
- R3: A write to address 0 sets the rate from write-data bits 13:0 at the clock edge of the strobe, so it reads back in the next cycle. A write never clears the counter.
- R4: With a nonzero rate N (N at least 2) and each request acknowledged at once, request rising edges come exactly N clocks apart.
- R5: If the rate is lowered to a value M below the present count, the counter wraps past 0x3FFF to 0 before matching M. The interval between the last request edge before the write and the next one is then 16384 + M clocks.
- R6: The request stays high until a cycle in which the acknowledge and the bus-ready input are both high. The request drops in the following cycle, unless a new match occurs in that same cycle. An acknowledge given while bus-ready is low has no effect.
- R7: A match that occurs while a request is still unaccepted leaves one single request pending and sets a sticky lost flag. The flag reads as bit 15 of the status word at address 1. A read of address 1 clears it, unless a new loss occurs in the same cycle.
- R8: A rate of 0 holds the counter at zero, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 1 | Register select: 0 = rate, 1 = status |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe; clears the lost flag when reading the status word |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the selected register |
| bus_ready_i | input | 1 | High when the bus is free to accept a refresh acknowledge |
| rfsh_ack_i | input | 1 | Refresh acknowledge from the DRAM controller |
| rfsh_req_o | output | 1 | Refresh request |

## Verification
The assertions check on every cycle how the counter steps, restarts and holds at zero. They also check that a written rate lands on the next edge, that the request holds until an accepted acknowledge, and when the lost flag is set or cleared. Some behaviours appear only over many cycles, and only the bench scenarios can show them. These are the actual spacing of requests for several rates, the wrap of almost 16384 clocks after the rate is lowered, and the single merged request with its cleared-on-read flag during a long busy stretch.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned RFSH_RATE_W = 14;
  localparam int unsigned RFSH_DATA_W = 16;
  localparam logic [RFSH_RATE_W-1:0] RFSH_RATE_RST = 14'h1FFF;

  typedef enum logic {
    RFSH_ADDR_RATE = 1'b0,
    RFSH_ADDR_STAT = 1'b1
  } rfsh_addr_e;
endpackage

// File: rtl/rfsh_rate_reg.sv
module rfsh_rate_reg #(
  parameter int unsigned RATE_W = 14,
  parameter logic [RATE_W-1:0] RST_VAL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [RATE_W-1:0] wdata_i,
  output logic [RATE_W-1:0] rate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rate_o <= RST_VAL;
    else if (wr_i) rate_o <= wdata_i;
  end
endmodule

// File: rtl/rfsh_match_cnt.sv
module rfsh_match_cnt #(
  parameter int unsigned RATE_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              match_o,
  output logic [RATE_W-1:0] cnt_o
);
  localparam logic [RATE_W-1:0] ONE = RATE_W'(1);

  logic              rate_zero;
  logic [RATE_W-1:0] cnt_d;

  assign rate_zero = (rate_i == '0);
  assign match_o   = !rate_zero && (cnt_o == rate_i);

  // restart at one: the match clock is the first clock of the new period
  always_comb begin
    if (rate_zero)    cnt_d = '0;
    else if (match_o) cnt_d = ONE;
    else              cnt_d = cnt_o + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end
endmodule

// File: rtl/rfsh_req_ctrl.sv
module rfsh_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic match_i,
  input  logic ack_i,
  input  logic ready_i,
  input  logic clr_lost_i,
  output logic req_o,
  output logic lost_o
);
  logic ack_ok;
  logic lose;

  assign ack_ok = req_o && ack_i && ready_i;
  assign lose   = match_i && req_o && !ack_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o  <= 1'b0;
      lost_o <= 1'b0;
    end else begin
      req_o <= match_i || (req_o && !ack_ok);
      if (lose)            lost_o <= 1'b1;
      else if (clr_lost_i) lost_o <= 1'b0;
    end
  end
endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import rfsh_pkg::*;
#(
  parameter int unsigned RATE_W = RFSH_RATE_W,
  parameter int unsigned DATA_W = RFSH_DATA_W,
  parameter logic [RATE_W-1:0] RATE_RST = RFSH_RATE_RST
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              bus_ready_i,
  input  logic              rfsh_ack_i,
  output logic              rfsh_req_o
);
  localparam int unsigned PAD_W = DATA_W - RATE_W;

  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] cnt_q;
  logic              match;
  logic              lost_q;
  logic              wr_rate;
  logic              rd_stat;
  logic [DATA_W-1:0] rate_word;
  logic [DATA_W-1:0] stat_word;

  assign wr_rate = reg_wr_i && (reg_addr_i == RFSH_ADDR_RATE);
  assign rd_stat = reg_rd_i && (reg_addr_i == RFSH_ADDR_STAT);

  rfsh_rate_reg #(.RATE_W(RATE_W), .RST_VAL(RATE_RST)) u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_rate),
    .wdata_i (reg_wdata_i[RATE_W-1:0]),
    .rate_o  (rate_q)
  );

  rfsh_match_cnt #(.RATE_W(RATE_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rate_i  (rate_q),
    .match_o (match),
    .cnt_o   (cnt_q)
  );

  rfsh_req_ctrl u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .match_i    (match),
    .ack_i      (rfsh_ack_i),
    .ready_i    (bus_ready_i),
    .clr_lost_i (rd_stat),
    .req_o      (rfsh_req_o),
    .lost_o     (lost_q)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rate_word = {{PAD_W{1'b0}}, rate_q};
    end else begin : g_nopad
      assign rate_word = rate_q[DATA_W-1:0];
    end
  endgenerate

  assign stat_word   = {lost_q, {(DATA_W-1){1'b0}}};
  assign reg_rdata_o = (reg_addr_i == RFSH_ADDR_STAT) ? stat_word : rate_word;
endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk #(
  parameter int unsigned RATE_W = 14,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              bus_ready_i,
  input logic              rfsh_ack_i,
  input logic              rfsh_req_o,
  input logic [RATE_W-1:0] rate_q,
  input logic [RATE_W-1:0] cnt_q,
  input logic              match,
  input logic              lost_q
);
  logic accepted;
  assign accepted = rfsh_req_o && rfsh_ack_i && bus_ready_i;

  // R3
  rate_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && !reg_addr_i |=> rate_q == $past(reg_wdata_i[RATE_W-1:0]));

  // R4
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_q != '0 && !match |=> RATE_W'(cnt_q - $past(cnt_q)) == RATE_W'(1));

  // R4
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> cnt_q == RATE_W'(1) && rfsh_req_o);

  // R8
  zero_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_q == '0 |=> cnt_q == '0);

  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfsh_req_o && !accepted |=> rfsh_req_o);

  // R6
  req_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accepted && !match |=> !rfsh_req_o);

  // R7
  lost_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && rfsh_req_o && !accepted |=> lost_q);

  // R7
  lost_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i && !(match && rfsh_req_o && !accepted) |=> !lost_q);
endmodule

bind refresh_timer refresh_timer_chk #(.RATE_W(RATE_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_wdata_i (reg_wdata_i),
  .bus_ready_i (bus_ready_i),
  .rfsh_ack_i  (rfsh_ack_i),
  .rfsh_req_o  (rfsh_req_o),
  .rate_q      (rate_q),
  .cnt_q       (cnt_q),
  .match       (match),
  .lost_q      (lost_q)
);

// File: tb/refresh_timer_tb.sv
module refresh_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  localparam logic [13:0] VEC_RATE [NVEC] = '{14'd2, 14'd5, 14'd9, 14'd17, 14'd64};
  localparam int          VEC_PER  [NVEC] = '{2, 5, 9, 17, 64};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ready = 1'b1;
  logic        ack;
  logic        req;
  logic        auto_ack = 1'b1;
  logic        ack_man = 1'b0;
  logic        ack_s = 1'b0;
  logic        req_prev = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int rise_cnt = 0;
  int last_rise = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ack = auto_ack ? ack_s : ack_man;

  refresh_timer u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_addr_i  (addr),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .bus_ready_i (ready),
    .rfsh_ack_i  (ack),
    .rfsh_req_o  (req)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    ack_s    <= req;
    req_prev <= req;
    if (rst_n && req && !req_prev) begin
      rise_cnt  <= rise_cnt + 1;
      last_rise <= cyc;
    end
  end

  task automatic check(input string req_tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    #1 rd = 1'b0;
  endtask

  task automatic wait_rise(input int limit);
    int start = rise_cnt;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      #1;
      if (rise_cnt > start) break;
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int t0, t1, rc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    check("R2 req", int'(req), 0);
    reg_read(1'b0, d);
    check("R2 rate", int'(d), 16'h1FFF);
    reg_read(1'b1, d);
    check("R2 status", int'(d), 0);

    // R1, R3: readback on the next cycle, reserved bits read 0
    reg_write(1'b0, 16'h1234);
    reg_read(1'b0, d);
    check("R3 write", int'(d), 16'h1234);
    reg_write(1'b0, 16'hC005);
    reg_read(1'b0, d);
    check("R1 reserved", int'(d), 16'h0005);

    // R4: table of rates and expected request spacing
    for (int v = 0; v < NVEC; v++) begin
      reg_write(1'b0, 16'h0000);
      reg_write(1'b0, {2'b00, VEC_RATE[v]});
      wait_rise(200);
      t0 = last_rise;
      wait_rise(200);
      t1 = last_rise;
      check("R4 period", t1 - t0, VEC_PER[v]);
    end

    // R8: rate 0 stops refresh
    reg_write(1'b0, 16'h0000);
    wait_cycles(4);
    rc = rise_cnt;
    wait_cycles(80);
    check("R8 no rise", rise_cnt - rc, 0);
    check("R8 req low", int'(req), 0);

    // R5 and R3 (no counter reset): lower the rate below the current count
    reg_write(1'b0, 16'd100);
    wait_rise(300);
    t0 = last_rise;
    wait_cycles(58);
    reg_write(1'b0, 16'd20);
    wait_rise(17000);
    t1 = last_rise;
    check("R5 wrap interval", t1 - t0, 16384 + 20);

    // R6, R7: bus held busy across several periods
    reg_write(1'b0, 16'h0000);
    wait_cycles(4);
    auto_ack = 1'b0;
    ack_man  = 1'b1;
    ready    = 1'b0;
    reg_write(1'b0, 16'd8);
    wait_cycles(40);
    check("R6 held while not ready", int'(req), 1);
    reg_write(1'b0, 16'h0000);
    reg_read(1'b1, d);
    check("R7 lost flag", int'(d), 16'h8000);
    reg_read(1'b1, d);
    check("R7 clear on read", int'(d), 0);
    wait_cycles(3);
    check("R6 ack ignored", int'(req), 1);
    @(negedge clk);
    ready = 1'b1;
    @(negedge clk);
    ack_man = 1'b0;
    check("R6 accepted", int'(req), 0);
    wait_cycles(10);
    check("R7 single request", int'(req), 0);
    reg_read(1'b1, d);
    check("R7 no new loss", int'(d), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule